// File: doc/BRIEF.md
# Three-Wire Serial Memory Command Decoder

This block is the slave-side front end of a small non-volatile memory reached over a three-wire serial link: a select line, a serial clock and a data input, plus a data output with an output enable. The three inputs are brought into the system clock domain through synchronizers, and rising edges of the serial clock are detected there. While select is high, the block waits for a leading one. It then collects a two-bit opcode and an address whose length depends on the word-width pin. Write-type commands also carry a data word. The block then decodes the command.

Reads are served from an attached synchronous array. The array is 16 bits wide, and its read data is valid one system cycle after the read enable. A dummy zero is sent first, then the word MSB first. While select stays high, further words follow at ascending addresses. The block holds a program-enable latch, which is cleared at reset. Erase and write commands become requests to an external cycle controller, held behind a valid/ready handshake. With the word-width pin high, words are 16 bits and addresses are `AW` bits. With it low, words are bytes and addresses are `AW+1` bits.

Top module: `sereep_cmd_dec`

## Requirements
- R1: After reset the output enable is low, no program request is pending and the program-enable latch is clear.
- R2: With select high, rising serial edges that sample the data input low before the first high one change nothing; the first high sample is the start bit.
- R3: The two bits after the start bit select the command: 10 read, 01 write, 11 erase, 00 extended; for extended commands the two most significant address bits select 11 enable, 00 disable, 10 erase-all, 01 write-all.
- R4: With the width pin high, the address is AW bits and the data word 16 bits; with it low, the address is AW+1 bits and the data word 8 bits, and address bit 0 picks the array word's upper byte (1) or lower byte (0) at array word address/2.
- R5: On a read, the output enable rises on the last address edge with the output low (dummy zero); each later rising serial edge presents the next bit, MSB first.
- R6: If select stays high after the last bit of a read word, the next rising edge presents the MSB of the word at the next address, wrapping from the top address to zero.
- R7: Erase, write, erase-all and write-all produce no request unless an enable command has completed since reset with no disable after it; reads work either way.
- R8: A completed program command raises a request with op 0 erase, 1 write, 2 erase-all, 3 write-all, the received address (zero for the whole-array ops) and the data (zero for erases, a byte in bits 7:0 in byte mode).
- R9: A pending request holds its valid and its fields unchanged until ready is seen high.
- R10: Once a command is complete, further serial clocks and data are ignored until select goes low.
- R11: Select low turns the output enable off and abandons a partly received command, but leaves a pending request in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| org_x16 | input | 1 | Word width select: 1 = 16-bit words, 0 = bytes |
| sp_cs | input | 1 | Serial select, active high |
| sp_clk | input | 1 | Serial clock |
| sp_di | input | 1 | Serial data in |
| sp_do | output | 1 | Serial data out |
| sp_do_oe | output | 1 | Output enable for sp_do |
| mem_rd_en | output | 1 | Array read strobe |
| mem_rd_addr | output | AW | Array word address |
| mem_rd_data | input | 16 | Array read data, valid one cycle after the strobe |
| pgm_valid | output | 1 | Program request pending |
| pgm_ready | input | 1 | Cycle controller accepts the request |
| pgm_op | output | 2 | Program operation code |
| pgm_addr | output | AW+1 | Program address |
| pgm_data | output | 16 | Program data |

## Verification
The hardest case to reach is the boundary between two words of a sequential read. There, the prefetched word has to arrive between two serial edges, and the address has to wrap at a limit that changes with the width pin. The stimulus holds select high through several words, starting both in the middle of the array and at the top address, in both widths. It compares every output bit against the model array. A second hard case is a pending request that must survive a select-low period and a stalled ready. This is reached by holding ready low across a command and its closing select-low.

// File: rtl/sed_pkg.sv
package sed_pkg;
  typedef enum logic [1:0] {
    PG_ERASE     = 2'd0,
    PG_WRITE     = 2'd1,
    PG_ERASE_ALL = 2'd2,
    PG_WRITE_ALL = 2'd3
  } pgm_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_DATA, S_READ, S_DONE
  } fe_state_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] EXT_DIS  = 2'b00;
  localparam logic [1:0] EXT_WALL = 2'b01;
  localparam logic [1:0] EXT_EALL = 2'b10;
  localparam logic [1:0] EXT_EN   = 2'b11;
endpackage

// File: rtl/sed_sync.sv
module sed_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sed_pgm_req.sv
module sed_pgm_req
  import sed_pkg::*;
#(
  parameter int AW = 6,
  localparam int AW8 = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  pgm_op_e        load_op,
  input  logic [AW8-1:0] load_addr,
  input  logic [15:0]    load_data,
  input  logic           ready,
  output logic           valid,
  output pgm_op_e        op,
  output logic [AW8-1:0] addr,
  output logic [15:0]    data
);
  logic           valid_n;
  pgm_op_e        op_n;
  logic [AW8-1:0] addr_n;
  logic [15:0]    data_n;

  always_comb begin
    valid_n = valid;
    op_n    = op;
    addr_n  = addr;
    data_n  = data;
    if (valid && ready) valid_n = 1'b0;
    if (load && !valid) begin
      valid_n = 1'b1;
      op_n    = load_op;
      addr_n  = load_addr;
      data_n  = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      op    <= PG_ERASE;
      addr  <= '0;
      data  <= '0;
    end else begin
      valid <= valid_n;
      op    <= op_n;
      addr  <= addr_n;
      data  <= data_n;
    end
  end
endmodule

// File: rtl/sed_frontend.sv
module sed_frontend
  import sed_pkg::*;
#(
  parameter int AW = 6,
  localparam int AW8  = AW + 1,
  localparam int CW   = AW8 + 2,
  localparam int CNTW = $clog2(CW + 17)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           org_x16,
  input  logic           cs_s,
  input  logic           sclk_s,
  input  logic           di_s,
  input  logic [15:0]    rd_data,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  output logic           do_q,
  output logic           do_oe,
  output logic           wen,
  output logic           req_load,
  output pgm_op_e        req_op,
  output logic [AW8-1:0] req_addr,
  output logic [15:0]    req_data
);
  fe_state_e      st, st_n;
  logic [CNTW-1:0] cnt, cnt_n;
  logic [CW-1:0]  sh, sh_n, sh_nx;
  logic [15:0]    dsh, dsh_n, dsh_nx;
  logic [AW8-1:0] ra, ra_n, ra_inc;
  logic [15:0]    word_q, word_n, osh, osh_n;
  logic           do_n, oe_n, rd_en_n, rd_vld, wen_n, sclk_d;
  pgm_op_e        cop, cop_n;
  logic [AW8-1:0] cadr, cadr_n;
  logic           rise;
  logic [1:0]     opc, ext;
  logic [AW8-1:0] adr;
  logic [CNTW-1:0] frame_last, data_last;

  assign rise       = sclk_s & ~sclk_d;
  assign sh_nx      = {sh[CW-2:0], di_s};
  assign dsh_nx     = {dsh[14:0], di_s};
  assign opc        = org_x16 ? sh_nx[AW+1:AW]   : sh_nx[AW8+1:AW8];
  assign ext        = org_x16 ? sh_nx[AW-1:AW-2] : sh_nx[AW8-1:AW8-2];
  assign adr        = org_x16 ? {1'b0, sh_nx[AW-1:0]} : sh_nx[AW8-1:0];
  assign frame_last = org_x16 ? CNTW'(AW + 1) : CNTW'(AW8 + 1);
  assign data_last  = org_x16 ? CNTW'(15) : CNTW'(7);
  assign ra_inc     = org_x16 ? {1'b0, ra[AW-1:0] + 1'b1} : ra + 1'b1;
  assign rd_addr    = org_x16 ? ra[AW-1:0] : ra[AW8-1:1];

  always_comb begin
    st_n     = st;
    cnt_n    = cnt;
    sh_n     = sh;
    dsh_n    = dsh;
    ra_n     = ra;
    osh_n    = osh;
    do_n     = do_q;
    oe_n     = do_oe;
    rd_en_n  = 1'b0;
    wen_n    = wen;
    cop_n    = cop;
    cadr_n   = cadr;
    req_load = 1'b0;
    req_op   = PG_ERASE;
    req_addr = '0;
    req_data = '0;
    word_n   = word_q;
    if (rd_vld)
      word_n = org_x16 ? rd_data
                       : {(ra[0] ? rd_data[15:8] : rd_data[7:0]), 8'h00};
    if (!cs_s) begin
      st_n  = S_IDLE;
      oe_n  = 1'b0;
      do_n  = 1'b0;
      cnt_n = '0;
    end else if (rise) begin
      unique case (st)
        S_IDLE: if (di_s) begin
          st_n  = S_CMD;
          cnt_n = '0;
          sh_n  = '0;
        end
        S_CMD: begin
          sh_n  = sh_nx;
          cnt_n = cnt + 1'b1;
          if (cnt == frame_last) begin
            st_n = S_DONE;
            unique case (opc)
              OPC_READ: begin
                st_n    = S_READ;
                ra_n    = adr;
                rd_en_n = 1'b1;
                cnt_n   = '0;
                oe_n    = 1'b1;
                do_n    = 1'b0;
              end
              OPC_WRITE: begin
                st_n   = S_DATA;
                cnt_n  = '0;
                cop_n  = PG_WRITE;
                cadr_n = adr;
              end
              OPC_ERASE: begin
                req_load = wen;
                req_op   = PG_ERASE;
                req_addr = adr;
              end
              default: begin
                unique case (ext)
                  EXT_EN:   wen_n = 1'b1;
                  EXT_DIS:  wen_n = 1'b0;
                  EXT_EALL: begin
                    req_load = wen;
                    req_op   = PG_ERASE_ALL;
                  end
                  default: begin
                    st_n   = S_DATA;
                    cnt_n  = '0;
                    cop_n  = PG_WRITE_ALL;
                    cadr_n = '0;
                  end
                endcase
              end
            endcase
          end
        end
        S_DATA: begin
          dsh_n = dsh_nx;
          cnt_n = cnt + 1'b1;
          if (cnt == data_last) begin
            st_n     = S_DONE;
            req_load = wen;
            req_op   = cop;
            req_addr = cadr;
            req_data = org_x16 ? dsh_nx : {8'h00, dsh_nx[7:0]};
          end
        end
        S_READ: begin
          if (cnt == '0) begin
            do_n    = word_q[15];
            osh_n   = {word_q[14:0], 1'b0};
            ra_n    = ra_inc;
            rd_en_n = 1'b1;
            cnt_n   = CNTW'(1);
          end else begin
            do_n  = osh[15];
            osh_n = {osh[14:0], 1'b0};
            cnt_n = (cnt == data_last) ? '0 : cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      dsh    <= '0;
      ra     <= '0;
      word_q <= '0;
      osh    <= '0;
      do_q   <= 1'b0;
      do_oe  <= 1'b0;
      rd_en  <= 1'b0;
      rd_vld <= 1'b0;
      wen    <= 1'b0;
      cop    <= PG_ERASE;
      cadr   <= '0;
      sclk_d <= 1'b0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      sh     <= sh_n;
      dsh    <= dsh_n;
      ra     <= ra_n;
      word_q <= word_n;
      osh    <= osh_n;
      do_q   <= do_n;
      do_oe  <= oe_n;
      rd_en  <= rd_en_n;
      rd_vld <= rd_en;
      wen    <= wen_n;
      cop    <= cop_n;
      cadr   <= cadr_n;
      sclk_d <= sclk_s;
    end
  end
endmodule

// File: rtl/sereep_cmd_dec.sv
module sereep_cmd_dec
  import sed_pkg::*;
#(
  parameter int AW = 6,
  localparam int AW8 = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           org_x16,
  input  logic           sp_cs,
  input  logic           sp_clk,
  input  logic           sp_di,
  output logic           sp_do,
  output logic           sp_do_oe,
  output logic           mem_rd_en,
  output logic [AW-1:0]  mem_rd_addr,
  input  logic [15:0]    mem_rd_data,
  output logic           pgm_valid,
  input  logic           pgm_ready,
  output logic [1:0]     pgm_op,
  output logic [AW8-1:0] pgm_addr,
  output logic [15:0]    pgm_data
);
  logic           cs_s, sclk_s, di_s, wen;
  logic           req_load;
  pgm_op_e        req_op, op_q;
  logic [AW8-1:0] req_addr;
  logic [15:0]    req_data;

  sed_sync #(.W(3), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sp_cs, sp_clk, sp_di}),
    .dout ({cs_s, sclk_s, di_s})
  );

  sed_frontend #(.AW(AW)) u_fe (
    .clk     (clk),
    .rst_n   (rst_n),
    .org_x16 (org_x16),
    .cs_s    (cs_s),
    .sclk_s  (sclk_s),
    .di_s    (di_s),
    .rd_data (mem_rd_data),
    .rd_en   (mem_rd_en),
    .rd_addr (mem_rd_addr),
    .do_q    (sp_do),
    .do_oe   (sp_do_oe),
    .wen     (wen),
    .req_load(req_load),
    .req_op  (req_op),
    .req_addr(req_addr),
    .req_data(req_data)
  );

  sed_pgm_req #(.AW(AW)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (req_load),
    .load_op  (req_op),
    .load_addr(req_addr),
    .load_data(req_data),
    .ready    (pgm_ready),
    .valid    (pgm_valid),
    .op       (op_q),
    .addr     (pgm_addr),
    .data     (pgm_data)
  );

  assign pgm_op = op_q;
endmodule

// File: rtl/sed_chk.sv
module sed_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_s,
  input logic          wen,
  input logic          do_oe,
  input logic          do_q,
  input logic          pgm_valid,
  input logic          pgm_ready,
  input logic [1:0]    pgm_op,
  input logic [AW:0]   pgm_addr,
  input logic [15:0]   pgm_data
);
  // R9
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_valid && !pgm_ready) |=> (pgm_valid && $stable(pgm_op) &&
                                   $stable(pgm_addr) && $stable(pgm_data)));

  // R11
  cs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !do_oe);

  // R5
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(do_oe) |-> !do_q);

  // R7
  enabled_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgm_valid) |-> $past(wen));
endmodule

bind sereep_cmd_dec sed_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_s     (cs_s),
  .wen      (wen),
  .do_oe    (sp_do_oe),
  .do_q     (sp_do),
  .pgm_valid(pgm_valid),
  .pgm_ready(pgm_ready),
  .pgm_op   (pgm_op),
  .pgm_addr (pgm_addr),
  .pgm_data (pgm_data)
);

// File: tb/sereep_cmd_dec_test.sv
module sereep_cmd_dec_test;
  localparam int AW = 6;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic org_x16 = 1'b1;
  logic sp_cs = 1'b0, sp_clk = 1'b0, sp_di = 1'b0;
  logic sp_do, sp_do_oe, mem_rd_en, pgm_valid;
  logic pgm_ready = 1'b1;
  logic [AW-1:0] mem_rd_addr;
  logic [15:0] mem_rd_data;
  logic [1:0] pgm_op;
  logic [AW:0] pgm_addr;
  logic [15:0] pgm_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [1:0]  exp_q[$];
  string       exp_tag[$];
  logic [1:0]  act_q[$];
  logic [24:0] pexp_q[$];
  string       pexp_tag[$];
  logic [15:0] mem [64];

  always #4 clk = ~clk;

  sereep_cmd_dec #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .org_x16(org_x16),
    .sp_cs(sp_cs), .sp_clk(sp_clk), .sp_di(sp_di),
    .sp_do(sp_do), .sp_do_oe(sp_do_oe),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .pgm_valid(pgm_valid), .pgm_ready(pgm_ready), .pgm_op(pgm_op),
    .pgm_addr(pgm_addr), .pgm_data(pgm_data)
  );

  function automatic logic [15:0] memw(input int i);
    return 16'((i * 257) ^ 16'h5A3C);
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: serial output bits
  always @(negedge clk) begin
    while (act_q.size() > 0) begin
      logic [1:0] a, e;
      string t;
      a = act_q.pop_front();
      if (exp_q.size() == 0) chk(0, "R5 unexpected bit", 32'(a), 32'h0);
      else begin
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        chk(a == e, t, 32'(a), 32'(e));
      end
    end
  end

  // monitor: program requests
  always @(negedge clk) begin
    if (rst_n && pgm_valid && pgm_ready) begin
      logic [24:0] a, e;
      a = {pgm_op, pgm_addr, pgm_data};
      if (pexp_q.size() == 0) chk(0, "R7 unexpected request", 32'(a), 32'h0);
      else begin
        e = pexp_q.pop_front();
        chk(a == e, pexp_tag.pop_front(), 32'(a), 32'(e));
      end
    end
  end

  task automatic sbit(input logic d, input bit cap);
    sp_di = d;
    repeat (H) @(negedge clk);
    if (cap) act_q.push_back({sp_do_oe, sp_do});
    sp_clk = 1'b1;
    repeat (H) @(negedge clk);
    sp_clk = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sbit(v[i], 0);
  endtask

  task automatic cs_high();
    sp_cs = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_low();
    sp_cs = 1'b0;
    sp_di = 1'b0;
    repeat (3 * H) @(negedge clk);
  endtask

  function automatic int alen();
    return org_x16 ? AW : AW + 1;
  endfunction

  function automatic int dlen();
    return org_x16 ? 16 : 8;
  endfunction

  task automatic frame(input logic [1:0] opc, input logic [31:0] adr,
                       input logic [31:0] dat, input bit with_data);
    sbit(1'b1, 0);
    send(32'(opc), 2);
    send(adr, alen());
    if (with_data) send(dat, dlen());
  endtask

  task automatic ext_cmd(input logic [1:0] sub);
    cs_high();
    frame(2'b00, 32'(sub) << (alen() - 2), 0, 0);
    cs_low();
  endtask

  task automatic expect_pgm(input logic [1:0] op, input int adr,
                            input logic [15:0] dat, input string tag);
    pexp_q.push_back({op, 7'(adr), dat});
    pexp_tag.push_back(tag);
  endtask

  task automatic do_read(input int a, input int nwords, input string tag);
    int ad = a;
    exp_q.push_back(2'b10);
    exp_tag.push_back({tag, " dummy"});
    for (int w = 0; w < nwords; w++) begin
      logic [15:0] v;
      v = org_x16 ? memw(ad)
                  : {(ad[0] ? memw(ad >> 1) >> 8 : memw(ad >> 1) & 16'hFF), 8'h00};
      for (int b = 0; b < dlen(); b++) begin
        exp_q.push_back({1'b1, v[15-b]});
        exp_tag.push_back(tag);
      end
      ad = org_x16 ? (ad + 1) % 64 : (ad + 1) % 128;
    end
    cs_high();
    frame(2'b10, 32'(a), 0, 0);
    for (int k = 0; k < 1 + nwords * dlen(); k++) sbit(1'b0, 1);
    cs_low();
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 0);
    finish_up();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = memw(i);
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(sp_do_oe == 0 && pgm_valid == 0, "R1 reset outputs", {sp_do_oe, pgm_valid}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R7: write before enable is dropped
    cs_high(); frame(2'b01, 5, 16'h1234, 1); cs_low();
    repeat (20) @(negedge clk);
    chk(pgm_valid == 0, "R7 write while disabled", pgm_valid, 0);

    // R3 enable, R2 leading zeros, R8 write
    ext_cmd(2'b11);
    expect_pgm(2'd1, 5, 16'hBEEF, "R2 R8 write after zeros");
    cs_high(); sbit(0, 0); sbit(0, 0); sbit(0, 0);
    frame(2'b01, 5, 16'hBEEF, 1); cs_low();

    // R3 R8 erase, erase-all, write-all
    expect_pgm(2'd0, 6'h2A, 0, "R8 erase");
    cs_high(); frame(2'b11, 6'h2A, 0, 0); cs_low();
    expect_pgm(2'd2, 0, 0, "R3 erase-all");
    ext_cmd(2'b10);
    expect_pgm(2'd3, 0, 16'h0F0F, "R3 write-all");
    cs_high(); frame(2'b00, 32'h10, 16'h0F0F, 1); cs_low();

    // R10: frame after a complete command is ignored
    expect_pgm(2'd0, 7, 0, "R10 erase");
    cs_high(); frame(2'b11, 7, 0, 0); frame(2'b01, 9, 16'h1111, 1); cs_low();

    // R9 R11: stalled request survives select low
    pgm_ready = 1'b0;
    expect_pgm(2'd0, 3, 0, "R9 stalled erase");
    cs_high(); frame(2'b11, 3, 0, 0); cs_low();
    repeat (30) @(negedge clk);
    chk(pgm_valid == 1 && pgm_addr == 3, "R9 R11 held request",
        {pgm_valid, 25'(pgm_addr)}, {1'b1, 25'd3});
    pgm_ready = 1'b1;
    repeat (5) @(negedge clk);

    // R11: partial frame abandoned
    cs_high(); sbit(1, 0); send(2'b01, 2); send(3'b101, 3); cs_low();
    expect_pgm(2'd0, 4, 0, "R11 after partial frame");
    cs_high(); frame(2'b11, 4, 0, 0); cs_low();
    repeat (10) @(negedge clk);

    // R7 disable
    ext_cmd(2'b00);
    cs_high(); frame(2'b11, 8, 0, 0); cs_low();
    repeat (20) @(negedge clk);
    chk(pgm_valid == 0, "R7 erase after disable", pgm_valid, 0);

    // R5 R6 R7 reads in x16
    do_read(10, 3, "R5 R7 read x16");
    do_read(63, 2, "R6 wrap x16");

    // R11: output off when select drops mid-read
    cs_high(); frame(2'b10, 1, 0, 0); sbit(0, 0); sbit(0, 0);
    chk(sp_do_oe == 1, "R5 oe during read", sp_do_oe, 1);
    cs_low();
    chk(sp_do_oe == 0, "R11 oe after select low", sp_do_oe, 0);

    // R4 byte mode
    org_x16 = 1'b0;
    ext_cmd(2'b11);
    expect_pgm(2'd1, 7'h45, 16'h005A, "R4 R8 byte write");
    cs_high(); frame(2'b01, 7'h45, 8'h5A, 1); cs_low();
    expect_pgm(2'd0, 7'h7F, 0, "R4 byte erase");
    cs_high(); frame(2'b11, 7'h7F, 0, 0); cs_low();
    do_read(5, 2, "R4 R6 byte read");
    do_read(127, 2, "R4 R6 byte wrap");

    repeat (50) @(negedge clk);
    chk(exp_q.size() == 0, "R5 pending bits", exp_q.size(), 0);
    chk(pexp_q.size() == 0, "R8 missing requests", pexp_q.size(), 0);
    finish_up();
  end
endmodule